// File: doc/BRIEF.md
# Two-Player Tug-of-War Game Controller

This block runs a two-button tug-of-war game on a row of indicator lamps. One lamp, the knot, is lit at a time. Each player has an active-low push-button. A press pulls the knot one place toward that player's end of the row. A player wins by pulling the knot off their own end. When that happens every lamp goes dark and a single seven-segment digit shows the winner.

Each raw button first passes through a flip-flop synchronizer chain. An edge detector then turns every press into a pulse exactly one clock wide, however long the button is held. The row is not a shift register. It is a chain of small per-lamp state machines, and each one decides its next state from its two neighbours and the move pulses. The centre cell is a separate variant that comes out of reset lit. A judge unit watches the two end lamps and latches the result, which drives the digit.

Top module: `tugwar_top`

## Requirements
- R1: While `rst` is high at a clock edge, the state after that edge has only the centre lamp lit (`lamp[4]` with 9 lamps) and `seg_n` = 7'h7F (blank).
- R2: During play exactly one lamp is lit. After a win no lamp is lit.
- R3: Buttons are active-low (0 = pressed) and pass through a two-stage synchronizer. One press, held for any number of cycles, moves the knot exactly one place.
- R4: A press of `btn_left_n` alone moves the lit lamp one index up, toward `lamp[8]`. A press of `btn_right_n` alone moves it one index down, toward `lamp[0]`.
- R5: When both press pulses occur in the same cycle, the knot does not move and no win is declared.
- R6: When `lamp[8]` is lit and a left press occurs alone, the left player wins. All lamps go off and `seg_n` = 7'h79 (digit 1). `seg_n` bits are {g,f,e,d,c,b,a}, and 0 lights a segment.
- R7: When `lamp[0]` is lit and a right press occurs alone, the right player wins. All lamps go off and `seg_n` = 7'h24 (digit 2).
- R8: After a win, further presses have no effect on the lamps or on `seg_n` until reset.
- R9: A reset in the middle of a game or after a win restores the R1 state, and play then resumes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_left_n | input | 1 | Left player button, active low, asynchronous |
| btn_right_n | input | 1 | Right player button, active low, asynchronous |
| lamp | output | 9 | Playfield lamps; index 8 is the left end, index 0 the right end |
| seg_n | output | 7 | Winner digit, active-low segments {g,f,e,d,c,b,a} |

## Verification
The bench marches the knot from the centre to each end with single-player presses. Hold lengths are swept from one to eight cycles, so a hold-sensitive edge detector, a wrong move direction or a missing end condition each give a different lamp pattern. A long sequence then mixes left, right and simultaneous presses. Its position is computed arithmetically, which separates correct cancellation of simultaneous presses from a bias toward either player. Presses after a win, and resets in mid-game and after a win, confirm that the result latches and that play restarts cleanly.

// File: rtl/tugwar_pkg.sv
package tugwar_pkg;
   // Segment codes, bit order {g,f,e,d,c,b,a}, 0 lights a segment
   localparam logic [6:0] SEG_BLANK = 7'h7F;
   localparam logic [6:0] SEG_ONE   = 7'h79;
   localparam logic [6:0] SEG_TWO   = 7'h24;

   typedef enum logic [1:0] {
      OUTCOME_OPEN  = 2'd0,
      OUTCOME_LEFT  = 2'd1,
      OUTCOME_RIGHT = 2'd2
   } outcome_e;
endpackage

// File: rtl/tugwar_press_pulse.sv
module tugwar_press_pulse #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_n,
   output logic pulse
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain;
   logic          held_q;

   generate
      if (STAGES < 1) begin : g_bad
         $error("tugwar_press_pulse: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= ~btn_n;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[LAST-1:0], ~btn_n};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) held_q <= 1'b0;
      else     held_q <= chain[LAST];
   end

   assign pulse = chain[LAST] & ~held_q;
endmodule

// File: rtl/tugwar_cell.sv
module tugwar_cell #(
   parameter bit CENTRE = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic nbr_left,
   input  logic nbr_right,
   input  logic step_left,
   input  logic step_right,
   output logic lit
);
   logic lit_next;

   always_comb begin
      lit_next = (lit & ~step_left & ~step_right)
               | (nbr_right & step_left)
               | (nbr_left & step_right);
   end

   generate
      if (CENTRE) begin : g_centre
         always_ff @(posedge clk) begin
            if (rst) lit <= 1'b1;
            else     lit <= lit_next;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (rst) lit <= 1'b0;
            else     lit <= lit_next;
         end
      end
   endgenerate
endmodule

// File: rtl/tugwar_judge.sv
module tugwar_judge
   import tugwar_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       end_left,
   input  logic       end_right,
   input  logic       step_left,
   input  logic       step_right,
   output logic [6:0] seg_n
);
   outcome_e outcome;

   always_ff @(posedge clk) begin
      if (rst) begin
         outcome <= OUTCOME_OPEN;
      end else if (outcome == OUTCOME_OPEN) begin
         if (end_left && step_left)        outcome <= OUTCOME_LEFT;
         else if (end_right && step_right) outcome <= OUTCOME_RIGHT;
      end
   end

   always_comb begin
      case (outcome)
         OUTCOME_LEFT:  seg_n = SEG_ONE;
         OUTCOME_RIGHT: seg_n = SEG_TWO;
         default:       seg_n = SEG_BLANK;
      endcase
   end
endmodule

// File: rtl/tugwar_top.sv
module tugwar_top #(
   parameter int N_LAMPS     = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               btn_left_n,
   input  logic               btn_right_n,
   output logic [N_LAMPS-1:0] lamp,
   output logic [6:0]         seg_n
);
   localparam int CENTRE_IDX = N_LAMPS / 2;

   generate
      if (N_LAMPS < 3 || (N_LAMPS % 2) == 0) begin : g_bad_lamps
         $error("tugwar_top: N_LAMPS must be odd and at least 3");
      end
   endgenerate

   logic pulse_l, pulse_r;
   logic step_l, step_r;
   logic [N_LAMPS+1:0] ring;

   tugwar_press_pulse #(.STAGES(SYNC_STAGES)) u_left_pulse (
      .clk(clk), .rst(rst), .btn_n(btn_left_n), .pulse(pulse_l)
   );
   tugwar_press_pulse #(.STAGES(SYNC_STAGES)) u_right_pulse (
      .clk(clk), .rst(rst), .btn_n(btn_right_n), .pulse(pulse_r)
   );

   // Simultaneous presses cancel
   assign step_l = pulse_l & ~pulse_r;
   assign step_r = pulse_r & ~pulse_l;

   // Lamp i sits at ring[i+1]; the ends see a permanently dark neighbour
   assign ring = {1'b0, lamp, 1'b0};

   generate
      for (genvar i = 0; i < N_LAMPS; i++) begin : g_cell
         tugwar_cell #(.CENTRE(i == CENTRE_IDX)) u_cell (
            .clk(clk), .rst(rst),
            .nbr_left(ring[i+2]), .nbr_right(ring[i]),
            .step_left(step_l), .step_right(step_r),
            .lit(lamp[i])
         );
      end
   endgenerate

   tugwar_judge u_judge (
      .clk(clk), .rst(rst),
      .end_left(lamp[N_LAMPS-1]), .end_right(lamp[0]),
      .step_left(step_l), .step_right(step_r),
      .seg_n(seg_n)
   );
endmodule

// File: rtl/tugwar_checker.sv
module tugwar_checker
   import tugwar_pkg::*;
#(
   parameter int N_LAMPS = 9
) (
   input logic               clk,
   input logic               rst,
   input logic [N_LAMPS-1:0] lamp,
   input logic [6:0]         seg_n,
   input logic               pl,
   input logic               pr
);
   localparam logic [N_LAMPS-1:0] HOME = N_LAMPS'(1) << (N_LAMPS / 2);

   assert_reset_home_R1: assert property (@(posedge clk)
      rst |=> (lamp == HOME && seg_n == SEG_BLANK));

   assert_single_knot_R2: assert property (@(posedge clk) disable iff (rst)
      (seg_n == SEG_BLANK) |-> $onehot(lamp));

   assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
      (pl |=> !pl) and (pr |=> !pr));

   assert_tie_holds_R5: assert property (@(posedge clk) disable iff (rst)
      (pl && pr) |=> ($stable(lamp) && $stable(seg_n)));

   assert_left_win_R6: assert property (@(posedge clk) disable iff (rst)
      (lamp[N_LAMPS-1] && pl && !pr) |=> (lamp == '0 && seg_n == SEG_ONE));

   assert_right_win_R7: assert property (@(posedge clk) disable iff (rst)
      (lamp[0] && pr && !pl) |=> (lamp == '0 && seg_n == SEG_TWO));

   assert_result_latched_R8: assert property (@(posedge clk) disable iff (rst)
      (seg_n != SEG_BLANK) |=> ($stable(seg_n) && lamp == '0));
endmodule

bind tugwar_top tugwar_checker #(.N_LAMPS(N_LAMPS)) u_chk (
   .clk(clk), .rst(rst), .lamp(lamp), .seg_n(seg_n),
   .pl(pulse_l), .pr(pulse_r)
);

// File: tb/tugwar_top_tb.sv
module tugwar_top_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bl_n = 1'b1;
   logic       br_n = 1'b1;
   logic [8:0] lamp;
   logic [6:0] seg_n;

   int n_vec  = 0;
   int n_fail = 0;
   int pos    = 4;
   int won    = 0;   // 0 none, 1 left, 2 right
   int cyc    = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   tugwar_top u_dut (
      .clk(clk), .rst(rst), .btn_left_n(bl_n), .btn_right_n(br_n),
      .lamp(lamp), .seg_n(seg_n)
   );

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         n_vec++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
         summary();
      end
   end

   task automatic check(string req);
      logic [8:0] exp_l;
      logic [6:0] exp_s;
      exp_l = (won != 0) ? 9'h000 : (9'(1) << pos);
      exp_s = (won == 1) ? 7'h79 : (won == 2) ? 7'h24 : 7'h7F;
      @(negedge clk);
      n_vec++;
      if (lamp !== exp_l || seg_n !== exp_s) begin
         n_fail++;
         $display("FAIL %s: actual lamp=%b seg=%h expected lamp=%b seg=%h",
                  req, lamp, seg_n, exp_l, exp_s);
      end
   endtask

   task automatic do_reset(string req);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      pos = 4;
      won = 0;
      check(req);
   endtask

   task automatic press(bit l, bit r, int hold, string req);
      @(negedge clk);
      bl_n = ~l;
      br_n = ~r;
      repeat (hold) @(negedge clk);
      bl_n = 1'b1;
      br_n = 1'b1;
      repeat (6) @(negedge clk);
      if (won == 0) begin
         if (l && !r) begin
            if (pos == 8) won = 1; else pos++;
         end else if (r && !l) begin
            if (pos == 0) won = 2; else pos--;
         end
      end
      check(req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check("R1 reset state");

      // R4 R3 R6: left march with swept hold lengths, then left win
      for (int i = 0; i < 5; i++) press(1'b1, 1'b0, i + 1, "R4/R3 left move, R6 left win");
      // R8: presses after a win are ignored
      for (int i = 0; i < 3; i++) press(1'b1, 1'b0, 2, "R8 after left win");
      press(1'b0, 1'b1, 3, "R8 right after left win");
      do_reset("R9 reset after win");

      // R4 R3 R7: right march, long holds
      for (int i = 0; i < 5; i++) press(1'b0, 1'b1, 8 - i, "R4/R3 right move, R7 right win");
      press(1'b1, 1'b0, 1, "R8 left after right win");
      do_reset("R9 reset after right win");

      // R5 R2: mixed sweep with simultaneous presses
      for (int i = 0; i < 60; i++) begin
         bit l, r;
         l = (i % 3) != 1;
         r = (i % 4) == 0 || (i % 7) == 3;
         if (l || r) press(l, r, (i % 5) + 1, "R5/R2 mixed sweep");
         if (won != 0) do_reset("R9 reset in sweep");
      end

      // R5 at both ends: ties never win
      for (int i = 0; i < 4; i++) press(1'b1, 1'b0, 1, "R4 to left end");
      press(1'b1, 1'b1, 4, "R5 tie at left end");
      do_reset("R9 reset");
      for (int i = 0; i < 4; i++) press(1'b0, 1'b1, 1, "R4 to right end");
      press(1'b1, 1'b1, 2, "R5 tie at right end");
      // R9: mid-game reset then resume
      do_reset("R9 mid-game reset");
      press(1'b0, 1'b1, 3, "R9 play resumes");

      done = 1'b1;
      summary();
   end
endmodule